// File: doc/BRIEF.md
# Descriptor-Driven FIFO Entry Unpacker

The block takes one 32-bit receive-side FIFO entry at a time and turns it into protocol words. The entry is split up by up to four programmable 10-bit extraction descriptors. Each descriptor names a start bit, a walking direction, a segment length of one to eight bits, and an end-of-entry flag. The descriptors are applied in a fixed order, one per clock. The extracted segments are concatenated into a word until the configured word width is reached, and the finished word is then presented on a valid/ready output stream.

The descriptor pair words and the word width are static while entries flow. The usual settings cover these packings:
- four words of up to 8 bits per entry;
- two words of up to 16 bits per entry;
- one word of up to 32 bits per entry.

A word may span several descriptors, and it may also span several entries. Entries arrive on a valid/ready input. A new entry is taken only after the previous one has been fully consumed.

Top module: `fifo_entry_unpacker`

## Requirements
- R1: Descriptor layout is start index in bits 9:5, direction in bit 4, length minus one in bits 3:1, and end flag in bit 0. Descriptor 0 is `desc_lo_i[9:0]`, descriptor 1 is `desc_lo_i[19:10]`, descriptor 2 is `desc_hi_i[9:0]`, and descriptor 3 is `desc_hi_i[19:10]`.
- R2: A descriptor takes length+1 bits from the entry, beginning at the start index. It walks downward when direction is 1 and upward when direction is 0. A position outside bits 31:0 reads as 0. Within the segment, the first bit taken is the most significant when direction is 1 and the least significant when direction is 0.
- R3: When direction is 1, each new segment is appended below the bits already gathered, so the first segment ends up most significant. When direction is 0, each new segment is placed above the bits already gathered, so the first segment ends up least significant.
- R4: A word is emitted as soon as the number of gathered bits reaches `word_bits_i` (legal range 1 to 32). The gathered count then restarts at zero. A partially gathered word carries over into the next entry.
- R5: Processing of an entry finishes with the descriptor whose end flag is set. The next entry starts again at descriptor 0.
- R6: If descriptors 0 to 2 carry no end flag, processing finishes after descriptor 3, whatever the flag of descriptor 3.
- R7: Exactly one descriptor is applied per clock, starting in the clock after the entry is accepted. `ent_ready_o` is low from acceptance until the finishing descriptor has been applied. An entry of n descriptors therefore holds `ent_ready_o` low for n clocks when the output is not stalled.
- R8: While `word_valid_o` is high and `word_ready_i` is low, `word_valid_o` stays high, `word_data_o` stays unchanged, and no descriptor is applied.
- R9: Reset leaves `ent_ready_o` high and `word_valid_o` low, and discards any partially gathered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_lo_i | input | 20 | Descriptors 0 (low half) and 1 (high half) |
| desc_hi_i | input | 20 | Descriptors 2 (low half) and 3 (high half) |
| word_bits_i | input | 6 | Bits per protocol word, 1 to 32 |
| ent_valid_i | input | 1 | FIFO entry offered |
| ent_data_i | input | 32 | FIFO entry |
| ent_ready_o | output | 1 | Entry accepted this clock when valid |
| word_valid_o | output | 1 | Protocol word available |
| word_data_o | output | 32 | Protocol word, right-aligned |
| word_ready_i | input | 1 | Consumer takes the word |

## Verification
Several wrong internal states show up at the ports within a few clocks:
- A wrong descriptor index or end decision changes how long `ent_ready_o` stays low, so the entry's busy time is counted against the number of descriptors it should use.
- A wrong gathered-bit count or accumulator value appears on the next emitted word. It can also appear up to one entry later when a word spans entries, so every word is compared against a behavioural model in arrival order.
- A lost stall shows as a dropped or repeated word under randomised `word_ready_i`.

// File: rtl/unpack_pkg.sv
package unpack_pkg;
  localparam int unsigned START_W = 5;
  localparam int unsigned LEN_W   = 3;
  localparam int unsigned DESC_W  = START_W + LEN_W + 2;

  // field order fixes the bit layout: start[9:5] dir[4] len_m1[3:1] last[0]
  typedef struct packed {
    logic [START_W-1:0] start;
    logic               dir;
    logic [LEN_W-1:0]   len_m1;
    logic               last;
  } desc_t;
endpackage

// File: rtl/unpack_desc_sel.sv
module unpack_desc_sel
  import unpack_pkg::*;
#(
  parameter int unsigned NUM_DESC = 4,
  parameter int unsigned IDX_W    = $clog2(NUM_DESC),
  parameter int unsigned CFG_W    = NUM_DESC * DESC_W / 2
) (
  input  logic [CFG_W-1:0] cfg_lo_i,
  input  logic [CFG_W-1:0] cfg_hi_i,
  input  logic [IDX_W-1:0] idx_i,
  output desc_t            desc_o
);
  localparam int unsigned ALL_W = 2 * CFG_W;

  logic [ALL_W-1:0] cfg_all;
  desc_t            descs [NUM_DESC];

  assign cfg_all = {cfg_hi_i, cfg_lo_i};

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_desc
    assign descs[g] = desc_t'(cfg_all[g*DESC_W +: DESC_W]);
  end

  assign desc_o = descs[idx_i];
endmodule

// File: rtl/unpack_seg_extract.sv
module unpack_seg_extract
  import unpack_pkg::*;
#(
  parameter int unsigned ENTRY_W = 32,
  parameter int unsigned SEG_MAX = 8,
  parameter int unsigned SEG_N_W = $clog2(SEG_MAX) + 1
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  desc_t              desc_i,
  output logic [SEG_MAX-1:0] seg_o,
  output logic [SEG_N_W-1:0] seg_n_o
);
  localparam int unsigned POS_W = $clog2(ENTRY_W);
  localparam int unsigned SI_W  = $clog2(SEG_MAX);

  always_comb begin
    seg_o = '0;
    for (int k = 0; k < SEG_MAX; k++) begin
      int   pos;
      int   slot;
      logic b;
      pos  = desc_i.dir ? int'(desc_i.start) - k : int'(desc_i.start) + k;
      b    = (pos >= 0 && pos < int'(ENTRY_W)) ? entry_i[pos[POS_W-1:0]] : 1'b0;
      // first bit taken lands on top for downward walks
      slot = desc_i.dir ? int'(desc_i.len_m1) - k : k;
      if (k <= int'(desc_i.len_m1)) seg_o[slot[SI_W-1:0]] = b;
    end
  end

  assign seg_n_o = SEG_N_W'(desc_i.len_m1) + SEG_N_W'(1);
endmodule

// File: rtl/unpack_word_asm.sv
module unpack_word_asm #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned SEG_MAX = 8,
  parameter int unsigned SEG_N_W = $clog2(SEG_MAX) + 1,
  parameter int unsigned CNT_W   = $clog2(WORD_W) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               dir_i,
  input  logic [SEG_MAX-1:0] seg_i,
  input  logic [SEG_N_W-1:0] seg_n_i,
  input  logic [CNT_W-1:0]   word_bits_i,
  input  logic               word_ready_i,
  output logic               word_valid_o,
  output logic [WORD_W-1:0]  word_data_o
);
  localparam int unsigned SUM_W = CNT_W + 1;

  logic [WORD_W-1:0] acc_q, acc_nxt, seg_ext;
  logic [CNT_W-1:0]  cnt_q;
  logic [SUM_W-1:0]  cnt_sum;
  logic              full;

  assign seg_ext = WORD_W'(seg_i);
  assign acc_nxt = dir_i ? ((acc_q << seg_n_i) | seg_ext) : (acc_q | (seg_ext << cnt_q));
  assign cnt_sum = SUM_W'(cnt_q) + SUM_W'(seg_n_i);
  assign full    = cnt_sum >= SUM_W'(word_bits_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q        <= '0;
      cnt_q        <= '0;
      word_valid_o <= 1'b0;
      word_data_o  <= '0;
    end else begin
      if (word_ready_i) word_valid_o <= 1'b0;
      if (step_i) begin
        if (full) begin
          acc_q        <= '0;
          cnt_q        <= '0;
          word_valid_o <= 1'b1;
          word_data_o  <= acc_nxt;
        end else begin
          acc_q <= acc_nxt;
          cnt_q <= cnt_sum[CNT_W-1:0];
        end
      end
    end
  end

  AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_data_o)); // R8

  AST_STALL_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |=> $stable(cnt_q) && $stable(acc_q)); // R8
endmodule

// File: rtl/fifo_entry_unpacker.sv
module fifo_entry_unpacker
  import unpack_pkg::*;
#(
  parameter int unsigned ENTRY_W  = 32,
  parameter int unsigned NUM_DESC = 4,
  parameter int unsigned SEG_MAX  = 8,
  localparam int unsigned CFG_W   = NUM_DESC * DESC_W / 2,
  localparam int unsigned CNT_W   = $clog2(ENTRY_W) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CFG_W-1:0]   desc_lo_i,
  input  logic [CFG_W-1:0]   desc_hi_i,
  input  logic [CNT_W-1:0]   word_bits_i,
  input  logic               ent_valid_i,
  input  logic [ENTRY_W-1:0] ent_data_i,
  output logic               ent_ready_o,
  output logic               word_valid_o,
  output logic [ENTRY_W-1:0] word_data_o,
  input  logic               word_ready_i
);
  localparam int unsigned IDX_W   = $clog2(NUM_DESC);
  localparam int unsigned SEG_N_W = $clog2(SEG_MAX) + 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_DESC - 1);

  logic               busy_q;
  logic [ENTRY_W-1:0] entry_q;
  logic [IDX_W-1:0]   idx_q;
  desc_t              cur;
  logic [SEG_MAX-1:0] seg;
  logic [SEG_N_W-1:0] seg_n;
  logic               step, fin;

  unpack_desc_sel #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .CFG_W(CFG_W)) u_sel (
    .cfg_lo_i (desc_lo_i),
    .cfg_hi_i (desc_hi_i),
    .idx_i    (idx_q),
    .desc_o   (cur)
  );

  unpack_seg_extract #(.ENTRY_W(ENTRY_W), .SEG_MAX(SEG_MAX), .SEG_N_W(SEG_N_W)) u_ext (
    .entry_i (entry_q),
    .desc_i  (cur),
    .seg_o   (seg),
    .seg_n_o (seg_n)
  );

  unpack_word_asm #(.WORD_W(ENTRY_W), .SEG_MAX(SEG_MAX), .SEG_N_W(SEG_N_W), .CNT_W(CNT_W)) u_asm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_i       (step),
    .dir_i        (cur.dir),
    .seg_i        (seg),
    .seg_n_i      (seg_n),
    .word_bits_i  (word_bits_i),
    .word_ready_i (word_ready_i),
    .word_valid_o (word_valid_o),
    .word_data_o  (word_data_o)
  );

  assign ent_ready_o = !busy_q;
  assign step        = busy_q && (!word_valid_o || word_ready_i);
  assign fin         = cur.last || (idx_q == IDX_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      entry_q <= '0;
      idx_q   <= '0;
    end else if (ent_valid_i && !busy_q) begin
      busy_q  <= 1'b1;
      entry_q <= ent_data_i;
      idx_q   <= '0;
    end else if (step) begin
      if (fin) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_i && ent_ready_o |=> !ent_ready_o); // R7

  AST_END_FLAG_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && cur.last |=> ent_ready_o); // R5

  AST_LAST_DESC_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && idx_q == IDX_LAST |=> ent_ready_o); // R6

  AST_IDLE_NO_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_ready_o && !word_valid_o |=> !word_valid_o); // R7

  AST_STALL_NO_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && word_valid_o && !word_ready_i |=> busy_q && $stable(idx_q)); // R8
endmodule

// File: tb/sim_fifo_entry_unpacker.sv
`timescale 1ns/1ps
module sim_fifo_entry_unpacker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] d_lo = '0, d_hi = '0;
  logic [5:0]  wbits = 6'd8;
  logic        e_valid = 1'b0;
  logic [31:0] e_data = '0;
  logic        e_ready;
  logic        w_valid;
  logic [31:0] w_data;
  logic        w_ready = 1'b1;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R9";
  logic [31:0] exp_q[$];
  logic [63:0] m_acc = '0;
  int m_cnt = 0;
  bit rnd_rdy = 0;
  int unsigned rs = 32'h1234_5678;
  int unsigned ds = 32'h0bad_cafe;
  bit prev_stall = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fifo_entry_unpacker u0 (
    .clk_i(clk), .rst_ni(rst_n), .desc_lo_i(d_lo), .desc_hi_i(d_hi),
    .word_bits_i(wbits), .ent_valid_i(e_valid), .ent_data_i(e_data),
    .ent_ready_o(e_ready), .word_valid_o(w_valid), .word_data_o(w_data),
    .word_ready_i(w_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] mk(input int st, input int dir, input int lm1, input int last);
    return 10'((st << 5) | (dir << 4) | (lm1 << 1) | last);
  endfunction

  function automatic logic [9:0] dsc(input int i);
    logic [39:0] all;
    all = {d_hi, d_lo};
    return all[i*10 +: 10];
  endfunction

  // behavioural model: returns number of descriptors used, pushes finished words
  function automatic int model(input logic [31:0] data);
    int used = 0;
    for (int v = 0; v < 4; v++) begin
      logic [9:0] d;
      int st, dir, n, last;
      logic [63:0] seg;
      d = dsc(v);
      st = int'(d[9:5]); dir = int'(d[4]); n = int'(d[3:1]) + 1; last = int'(d[0]);
      seg = '0;
      for (int k = 0; k < n; k++) begin
        int p;
        logic b;
        p = dir ? st - k : st + k;
        b = (p >= 0 && p < 32) ? data[p] : 1'b0;
        if (dir) seg = (seg << 1) | 64'(b);
        else seg = seg | (64'(b) << k);
      end
      if (dir) m_acc = (m_acc << n) | seg;
      else m_acc = m_acc | (seg << m_cnt);
      m_cnt += n;
      if (m_cnt >= int'(wbits)) begin
        exp_q.push_back(m_acc[31:0]);
        m_acc = '0;
        m_cnt = 0;
      end
      used++;
      if (last != 0) break;
    end
    return used;
  endfunction

  function automatic logic [31:0] nxt();
    ds = ds * 1103515245 + 12345;
    return ds;
  endfunction

  task automatic send(input logic [31:0] data, input bit measure);
    int n, cyc;
    @(negedge clk);
    while (!e_ready) @(negedge clk);
    e_valid = 1'b1;
    e_data  = data;
    n = model(data);
    @(posedge clk);
    #1 e_valid = 1'b0;
    if (measure) begin
      cyc = 0;
      forever begin
        @(negedge clk);
        if (e_ready) break;
        cyc++;
      end
      chk(cyc == n, {cur_req, " R7 busy clocks"}, 32'(cyc), 32'(n));
    end
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_q.size() != 0 || w_valid || !e_ready) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(exp_q.size() == 0, {cur_req, " all words emitted"}, 32'(exp_q.size()), 32'd0);
  endtask

  // output checker, every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (rnd_rdy) begin
        rs = rs * 1664525 + 1013904223;
        w_ready = rs[16] | rs[9];
      end else w_ready = 1'b1;
      if (prev_stall) chk(w_valid, "R8 valid held", 32'(w_valid), 32'd1);
      if (w_valid) begin
        if (exp_q.size() == 0) chk(1'b0, {cur_req, " unexpected word"}, w_data, 32'hx);
        else begin
          chk(w_data == exp_q[0], cur_req, w_data, exp_q[0]);
          if (w_ready) void'(exp_q.pop_front());
        end
      end
      prev_stall = w_valid && !w_ready;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(e_ready == 1'b1, "R9 ready after reset", 32'(e_ready), 32'd1);
    chk(w_valid == 1'b0, "R9 no word in reset", 32'(w_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(e_ready == 1'b1 && w_valid == 1'b0, "R9 idle after reset", {30'd0, e_ready, w_valid}, 32'h2);

    // four 8-bit lanes, upward
    cur_req = "R1 R2 R3 4x8 up";
    wbits = 6'd8;
    d_lo = {mk(8, 0, 7, 0), mk(0, 0, 7, 0)};
    d_hi = {mk(24, 0, 7, 1), mk(16, 0, 7, 0)};
    send(32'hA1B2C3D4, 1);
    for (int i = 0; i < 6; i++) send(nxt(), 1);
    drain();

    // 7-bit words, downward
    cur_req = "R2 R3 4x7 down";
    wbits = 6'd7;
    d_lo = {mk(14, 1, 6, 0), mk(6, 1, 6, 0)};
    d_hi = {mk(30, 1, 6, 1), mk(22, 1, 6, 0)};
    for (int i = 0; i < 6; i++) send(nxt(), 1);
    drain();

    // 15-bit words across two descriptors, upward
    cur_req = "R3 R4 2x15 up";
    wbits = 6'd15;
    d_lo = {mk(8, 0, 6, 0), mk(0, 0, 7, 0)};
    d_hi = {mk(24, 0, 6, 1), mk(16, 0, 7, 0)};
    send(32'h7FFF_0001, 1);
    for (int i = 0; i < 6; i++) send(nxt(), 1);
    drain();

    // 23-bit word ending at descriptor 2, downward
    cur_req = "R5 R3 1x23 down";
    wbits = 6'd23;
    d_lo = {mk(14, 1, 7, 0), mk(22, 1, 7, 0)};
    d_hi = {mk(0, 1, 0, 0), mk(6, 1, 6, 1)};
    for (int i = 0; i < 6; i++) send(nxt(), 1);
    drain();

    // no end flag anywhere
    cur_req = "R6 no end flag";
    wbits = 6'd8;
    d_lo = {mk(8, 0, 7, 0), mk(0, 0, 7, 0)};
    d_hi = {mk(24, 0, 7, 0), mk(16, 0, 7, 0)};
    for (int i = 0; i < 4; i++) send(nxt(), 1);
    drain();

    // end flag on descriptor 0, next entry restarts at 0
    cur_req = "R5 end at first";
    wbits = 6'd8;
    d_lo = {mk(0, 0, 7, 1), mk(20, 1, 7, 1)};
    d_hi = {mk(9, 0, 3, 1), mk(3, 0, 2, 0)};
    for (int i = 0; i < 5; i++) send(nxt(), 1);
    drain();

    // word spans entries
    cur_req = "R4 word across entries";
    wbits = 6'd16;
    d_lo = {mk(0, 0, 0, 0), mk(4, 0, 7, 1)};
    d_hi = '0;
    for (int i = 0; i < 6; i++) send(nxt(), 1);
    drain();

    // positions off the entry read zero
    cur_req = "R2 out of range";
    wbits = 6'd16;
    d_lo = {mk(29, 0, 7, 1), mk(2, 1, 7, 0)};
    d_hi = '0;
    send(32'hFFFF_FFFF, 1);
    send(32'hE000_0005, 1);
    drain();

    // random backpressure
    rnd_rdy = 1;
    cur_req = "R8 stall 2x15";
    wbits = 6'd15;
    d_lo = {mk(8, 0, 6, 0), mk(0, 0, 7, 0)};
    d_hi = {mk(24, 0, 6, 1), mk(16, 0, 7, 0)};
    for (int i = 0; i < 40; i++) send(nxt(), 0);
    drain();
    cur_req = "R8 stall 4x7 down";
    wbits = 6'd7;
    d_lo = {mk(14, 1, 6, 0), mk(6, 1, 6, 0)};
    d_hi = {mk(30, 1, 6, 1), mk(22, 1, 6, 0)};
    for (int i = 0; i < 40; i++) send(nxt(), 0);
    drain();
    rnd_rdy = 0;

    // reset drops a partial word
    cur_req = "R9 partial cleared";
    wbits = 6'd16;
    d_lo = {mk(0, 0, 0, 0), mk(0, 0, 7, 1)};
    d_hi = '0;
    send(32'h0000_00AA, 1);
    @(negedge clk);
    rst_n = 1'b0;
    m_acc = '0;
    m_cnt = 0;
    #1;
    chk(e_ready == 1'b1 && w_valid == 1'b0, "R9 reset mid-word", {30'd0, e_ready, w_valid}, 32'h2);
    @(negedge clk);
    rst_n = 1'b1;
    send(32'h0000_0011, 1);
    send(32'h0000_0022, 1);
    chk(exp_q.size() == 1 && exp_q[exp_q.size()-1] == 32'h2211, "R9 model word", exp_q[0], 32'h2211);
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule